// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits beside an SDRAM command engine. It holds the programmable fields of the device mode word and produces the column address for each data beat of a read or write burst. It does not issue DRAM commands and does not model the storage array.

A controller loads a 12-bit mode word with `mode_load`. The block decodes four fields from it: the burst length, the wrap type, the CAS latency and the single-write option. If a word carries a reserved length or latency code, the block rejects the whole word and keeps the previous setting.

A controller then pulses `start` with a start column and a read/write flag. From the next cycle on, the block presents one column per cycle on `col_out`, with `col_valid` high. It raises `last_beat` on the final beat of a bounded burst. A full-page burst walks all columns of the row and keeps going until `stop` is asserted. A new `start` during a burst restarts the sequence from the new column.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `col_valid`, `last_beat` and `mode_bad` are 0, `col_out` is 0 and `cas_lat` is 2. The default burst is length 1 in sequential order.
- R2: Mode bits 2..0 set the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page. Mode bit 3 sets the wrap type: 0=sequential, 1=interleave.
- R3: Mode bits 6..4 set the latency: 010 gives `cas_lat`=2 and 011 gives `cas_lat`=3.
- R4: In sequential order, beat i of a burst of length L starting at column c outputs the upper bits of c unchanged, with low bits equal to (c+i) mod L.
- R5: In interleave order, beat i outputs c XOR i. The upper bits above the burst boundary stay fixed.
- R6: A full-page burst outputs (c+i) mod 256 and wraps without end. It never raises `last_beat` and runs until `stop`. Mode bit 3 is ignored in this mode.
- R7: When mode bit 9 is 1, a write burst has exactly one beat. A read burst keeps the programmed length.
- R8: When `stop` is sampled high during a burst, the beat shown in that cycle is the final one and `col_valid` is 0 in the next cycle. This holds for every length. `stop` while idle has no effect.
- R9: A mode word with a reserved length code or a reserved latency code sets `mode_bad` to 1. It leaves the length, wrap, latency and single-write settings unchanged. A valid word clears `mode_bad`.
- R10: A `start` during an active burst restarts the sequence at the new column, with the length in force at that moment.
- R11: `start` is sampled at a clock edge, beat 0 (column c) appears in the following cycle, and one beat follows per cycle. `last_beat` is high only on beat L-1, and `col_valid` falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Load `mode_word` into the mode fields |
| mode_word | input | 12 | Mode word |
| start | input | 1 | Begin a burst |
| start_col | input | 8 | Start column |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| stop | input | 1 | Terminate the current burst |
| col_out | output | 8 | Column of the current beat (0 when idle) |
| col_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final one of a bounded burst |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| mode_bad | output | 1 | Last mode word was rejected |

## Verification
The sequencing is swept over every start column, for each bounded length and both wrap types, using read bursts. This sweep separates a wrong modulo boundary from a wrong XOR pattern, because the two orders agree only at some offsets. A long full-page run from column 250 crosses column 255, which checks the 256-column wrap and confirms that `last_beat` never rises. Separate sequences cover the following cases:
- single-write writes against reads of the same length;
- stop in mid-burst;
- a restart in mid-burst;
- reserved length and latency words followed by bursts, which show the retained setting.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              is_write,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              last_beat,
  output logic [1:0]        cas_lat,
  output logic              mode_bad
);

  logic [2:0]       m_len;
  logic             m_il, m_lat3, m_sw;
  logic             busy, b_full, b_il;
  logic [COL_W-1:0] base, beat, b_mask;

  wire [2:0] w_len = mode_word[2:0];
  wire [2:0] w_lat = mode_word[6:4];
  wire len_ok = (w_len[2] == 1'b0) || (w_len == 3'b111);
  wire lat_ok = (w_lat == 3'b010) || (w_lat == 3'b011);

  wire one_beat = is_write && m_sw;
  wire full_req = (m_len == 3'b111) && !one_beat;
  logic [COL_W-1:0] new_mask;
  always_comb begin
    new_mask = '0;
    if (!one_beat) begin
      case (m_len)
        3'b001:  new_mask = COL_W'(1);
        3'b010:  new_mask = COL_W'(3);
        3'b011:  new_mask = COL_W'(7);
        3'b111:  new_mask = '1;
        default: new_mask = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len    <= 3'b000;
      m_il     <= 1'b0;
      m_lat3   <= 1'b0;
      m_sw     <= 1'b0;
      mode_bad <= 1'b0;
    end else if (mode_load) begin
      if (len_ok && lat_ok) begin
        m_len    <= w_len;
        m_il     <= mode_word[3];
        m_lat3   <= w_lat[0];
        m_sw     <= mode_word[9];
        mode_bad <= 1'b0;
      end else begin
        mode_bad <= 1'b1;
      end
    end
  end

  wire at_end = !b_full && (beat == b_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base   <= '0;
      beat   <= '0;
      b_mask <= '0;
      b_full <= 1'b0;
      b_il   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      base   <= start_col;
      beat   <= '0;
      b_mask <= new_mask;
      b_full <= full_req;
      b_il   <= m_il && !full_req;
    end else if (busy) begin
      if (stop || at_end) busy <= 1'b0;
      else                beat <= beat + 1'b1;
    end
  end

  wire [COL_W-1:0] seq_col = (base & ~b_mask) | ((base + beat) & b_mask);
  wire [COL_W-1:0] il_col  = base ^ beat;

  assign col_out   = busy ? (b_il ? il_col : seq_col) : '0;
  assign col_valid = busy;
  assign last_beat = busy && at_end;
  assign cas_lat   = m_lat3 ? 2'd3 : 2'd2;

endmodule

module burst_col_seq_chk #(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_load,
  input logic [MODE_W-1:0] mode_word,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic              stop,
  input logic [COL_W-1:0]  col_out,
  input logic              col_valid,
  input logic              last_beat,
  input logic [1:0]        cas_lat,
  input logic              mode_bad
);

  wire bad_word = !((mode_word[2] == 1'b0) || (mode_word[2:0] == 3'b111)) ||
                  !((mode_word[6:4] == 3'b010) || (mode_word[6:4] == 3'b011));

  a_r1_idle_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (col_out == '0));

  a_r11_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  a_r11_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col_out == $past(start_col)));

  a_r11_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !col_valid);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && stop && !start) |=> !col_valid);

  a_r11_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !last_beat && !stop) |=> col_valid);

  a_r9_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && bad_word) |=> mode_bad && $stable(cas_lat));

  a_r3_lat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2) || (cas_lat == 2'd3));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
  .start(start), .start_col(start_col), .stop(stop), .col_out(col_out),
  .col_valid(col_valid), .last_beat(last_beat), .cas_lat(cas_lat),
  .mode_bad(mode_bad)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  logic        clk = 0, rst_n = 0;
  logic        mode_load = 0, start = 0, is_write = 0, stop = 0;
  logic [11:0] mode_word = '0;
  logic [7:0]  start_col = '0;
  logic [7:0]  col_out;
  logic        col_valid, last_beat, mode_bad;
  logic [1:0]  cas_lat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_col_seq dut (.*);

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic load(logic [11:0] w);
    @(negedge clk); mode_load = 1; mode_word = w;
    @(negedge clk); mode_load = 0;
  endtask

  function automatic int exp_col(int c, int i, int len, bit il);
    int m = len - 1;
    if (il) return c ^ i;
    return (c & ~m & 255) | ((c + i) & m);
  endfunction

  // full burst with expected length len and ordering il
  task automatic burst(string r, int c, bit wr, int len, bit il);
    @(negedge clk); start = 1; start_col = 8'(c); is_write = wr;
    @(negedge clk); start = 0;
    for (int i = 0; i < len; i++) begin
      chk(r, col_valid, 1);
      chk(r, col_out, exp_col(c, i, len, il));
      chk(r, last_beat, (i == len - 1) ? 1 : 0);
      if (i < len - 1) @(negedge clk);
    end
    @(negedge clk);
    chk({r, " end"}, col_valid, 0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[4] = '{1, 2, 4, 8};
    repeat (3) @(negedge clk);
    chk("R1 valid", col_valid, 0);
    chk("R1 last", last_beat, 0);
    chk("R1 col", col_out, 0);
    chk("R1 lat", cas_lat, 2);
    chk("R1 bad", mode_bad, 0);
    rst_n = 1;
    burst("R1 default len1", 77, 0, 1, 0);

    // R2 R4 R5 R11 sweep
    for (int li = 0; li < 4; li++)
      for (int il = 0; il < 2; il++) begin
        load(12'h020 | 12'(il << 3) | 12'(li));
        for (int c = 0; c < 256; c++)
          burst(il ? "R5 R2 interleave" : "R4 R2 sequential", c, 0, lens[li], il[0]);
      end

    // R3
    load(12'h032);
    chk("R3 lat3", cas_lat, 3);
    load(12'h022);
    chk("R3 lat2", cas_lat, 2);

    // R7 single write
    load(12'h222);
    burst("R7 write one beat", 3, 1, 1, 0);
    burst("R7 read keeps len", 3, 0, 4, 0);
    load(12'h022);
    burst("R7 off write len4", 3, 1, 4, 0);

    // R6 full page, wrap bit set but ignored
    load(12'h02F);
    @(negedge clk); start = 1; start_col = 250; is_write = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < 300; i++) begin
      chk("R6 valid", col_valid, 1);
      chk("R6 col", col_out, (250 + i) % 256);
      chk("R6 no last", last_beat, 0);
      if (i == 299) stop = 1;
      @(negedge clk);
    end
    stop = 0;
    chk("R6 R8 stopped", col_valid, 0);

    // R8 stop mid burst, and stop while idle
    load(12'h023);
    @(negedge clk); start = 1; start_col = 9;
    @(negedge clk); start = 0;
    chk("R8 beat0", col_out, 9);
    @(negedge clk);
    chk("R8 beat1", col_out, 10);
    stop = 1;
    @(negedge clk); stop = 0;
    chk("R8 stop ends", col_valid, 0);
    stop = 1;
    @(negedge clk); stop = 0;
    chk("R8 idle stop", col_valid, 0);
    burst("R8 after idle stop", 9, 0, 8, 0);

    // R10 restart
    @(negedge clk); start = 1; start_col = 16;
    @(negedge clk); start = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 pre", col_out, 18);
    start = 1; start_col = 41;
    @(negedge clk); start = 0;
    for (int i = 0; i < 8; i++) begin
      chk("R10 col", col_out, exp_col(41, i, 8, 0));
      chk("R10 last", last_beat, (i == 7) ? 1 : 0);
      @(negedge clk);
    end
    chk("R10 end", col_valid, 0);

    // R9 reserved codes
    load(12'h03A);
    chk("R9 lat3 loaded", cas_lat, 3);
    load(12'h024);
    chk("R9 bad len", mode_bad, 1);
    chk("R9 lat kept", cas_lat, 3);
    burst("R9 setting kept", 5, 0, 4, 1);
    load(12'h012);
    chk("R9 bad lat", mode_bad, 1);
    chk("R9 lat kept2", cas_lat, 3);
    burst("R9 setting kept2", 6, 0, 4, 1);
    load(12'h021);
    chk("R9 cleared", mode_bad, 0);
    chk("R9 new lat", cas_lat, 2);
    burst("R9 new len", 6, 0, 2, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule